// File: doc/BRIEF.md
# Exception Entry Sequencer

This unit performs the state changes a processor needs on entering an exception handler for three exception kinds: an illegal instruction found in ordinary flow, an illegal instruction found in the slot behind a delayed branch, and a user break trap. A break trap can be taken either before or after the instruction that matched the break condition. The pipeline presents one strobe per kind. The slot kind arrives as a vector of cause flags. Alongside the strobes the pipeline presents the current instruction address, the address of the delayed branch that owns the slot, a before/after qualifier for breaks, the live status word and the vector base.

In a single clock edge the unit chooses one request and captures a return address and the old status word into shadow registers. On that edge it also records an event code, forms a new status word with the block, privilege and bank bits forced to one, and emits a redirect address equal to the vector base plus a fixed offset. A one-cycle valid pulse accompanies the redirect. The block bit acts as the interlock: a request that arrives while the block bit is already set is refused, and the unit reports the refusal instead of entering.

Top module: `exc_entry_seq`

## Requirements
- R1: While `rst_n` is low and after its release, `redirect_valid`, `blocked_err`, `redirect_pc`, `sr_out`, `saved_pc`, `saved_sr` and `event_code` all read zero until the first accepted or refused request.
- R2: An accepted illegal-instruction request stores `cur_pc` in `saved_pc` and `sr_in` in `saved_sr`, and sets `event_code` to 0x180.
- R3: An accepted slot request stores `branch_pc` (not `cur_pc`) in `saved_pc` and `sr_in` in `saved_sr`, and sets `event_code` to 0x1A0.
- R4: A slot request is any nonzero `slot_cause`. Bit 0 flags an undefined code, bit 1 an instruction that rewrites the PC, bit 2 a privileged instruction in user mode, and bit 3 a DSP instruction while DSP mode is off. Each bit alone causes a slot entry.
- R5: An accepted break request sets `event_code` to 0x1E0 and stores `sr_in` in `saved_sr`. With `break_post` low, `saved_pc` is `cur_pc`. With `break_post` high, `saved_pc` is `cur_pc` + 2 modulo 2^PC_W.
- R6: On entry, `sr_out` equals `sr_in` with bits 28 (block), 29 (bank) and 30 (privilege) forced to 1 and all other bits unchanged.
- R7: On entry, `redirect_pc` equals `vec_base` + 0x100 modulo 2^PC_W.
- R8: When several requests arrive in one cycle, slot wins over illegal and illegal wins over break. Exactly one entry is made.
- R9: A request that arrives while `sr_in` bit 28 is 1 is refused. `blocked_err` pulses for one cycle, `redirect_valid` stays low, and `saved_pc`, `saved_sr`, `event_code`, `redirect_pc` and `sr_out` keep their values.
- R10: All outputs of an entry change on the clock edge that samples the request. `redirect_valid` is high for that single cycle and low again after an idle edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_cause | input | 4 | Slot exception cause flags (R4 encoding) |
| req_illegal | input | 1 | Illegal instruction request |
| req_break | input | 1 | User break request |
| break_post | input | 1 | 1 = break after execution, 0 = before |
| cur_pc | input | PC_W | Address of the faulting or breaking instruction |
| branch_pc | input | PC_W | Address of the delayed branch owning the slot |
| sr_in | input | SR_W | Live status word |
| vec_base | input | PC_W | Vector base address |
| redirect_valid | output | 1 | One-cycle pulse with a new fetch address |
| redirect_pc | output | PC_W | Handler entry address |
| sr_out | output | SR_W | Status word to install on entry |
| saved_pc | output | PC_W | Shadow return address |
| saved_sr | output | SR_W | Shadow status word |
| event_code | output | 12 | Code of the last exception entered |
| blocked_err | output | 1 | One-cycle pulse on a refused request |

## Verification
The bench builds the unit with a 16-bit address width and keeps the status word at 32 bits. At that width the wrap of the post-break return address from 0xFFFE to 0x0000 and the wrap of the redirect sum from a vector base of 0xFF80 can be reached with ordinary table entries. The 32-bit status word still holds the three forced bits at their real positions. A refused request is checked through the held shadow registers, so the bench can tell a refusal apart from an entry that happened to store the same values.

// File: rtl/exc_entry_pkg.sv
// Package: shared kinds and event codes for the exception entry sequencer.
// Assumes 12-bit event codes; the encoding of the kind enum is internal only.
package exc_entry_pkg;

    localparam int EC_W = 12;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_SLOT  = 2'd1,
        KIND_ILL   = 2'd2,
        KIND_BRK   = 2'd3
    } exc_kind_e;

    localparam logic [EC_W-1:0] CODE_ILL  = 12'h180;
    localparam logic [EC_W-1:0] CODE_SLOT = 12'h1A0;
    localparam logic [EC_W-1:0] CODE_BRK  = 12'h1E0;

    // Maps an exception kind to the code written into the event register.
    function automatic logic [EC_W-1:0] code_of(exc_kind_e k);
        case (k)
            KIND_SLOT: code_of = CODE_SLOT;
            KIND_ILL:  code_of = CODE_ILL;
            KIND_BRK:  code_of = CODE_BRK;
            default:   code_of = '0;
        endcase
    endfunction

endpackage

// File: rtl/exc_prio_arb.sv
// Priority arbiter: slot over illegal over break. A pending request is either
// accepted or, when the block bit is set, rejected. Purely combinational.
module exc_prio_arb
    import exc_entry_pkg::*;
#(
    parameter int SLOT_CAUSES = 4
) (
    input  logic [SLOT_CAUSES-1:0] slot_cause,
    input  logic                   req_illegal,
    input  logic                   req_break,
    input  logic                   blocked,
    output exc_kind_e              kind,
    output logic                   accept,
    output logic                   reject
);

    logic slot_any;
    logic any_req;

    // Collapse the slot cause flags into one request.
    always_comb slot_any = |slot_cause;

    // Fixed-priority choice of the winning kind.
    always_comb begin
        if (slot_any)         kind = KIND_SLOT;
        else if (req_illegal) kind = KIND_ILL;
        else if (req_break)   kind = KIND_BRK;
        else                  kind = KIND_NONE;
    end

    // Split a pending request into accept or reject on the block bit.
    always_comb begin
        any_req = slot_any | req_illegal | req_break;
        accept  = any_req & ~blocked;
        reject  = any_req &  blocked;
    end

endmodule

// File: rtl/exc_ret_pc.sv
// Return address select: branch address for slot faults, next address for a
// post-execution break, current address otherwise. Assumes fixed-length
// instructions of INSN_BYTES bytes; sums wrap modulo 2^PC_W.
module exc_ret_pc
    import exc_entry_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int INSN_BYTES = 2
) (
    input  exc_kind_e         kind,
    input  logic              break_post,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [PC_W-1:0]   branch_pc,
    output logic [PC_W-1:0]   ret_pc
);

    localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

    // Choose the address the handler will return to.
    always_comb begin
        case (kind)
            KIND_SLOT: ret_pc = branch_pc;
            KIND_BRK:  ret_pc = break_post ? (cur_pc + STEP) : cur_pc;
            default:   ret_pc = cur_pc;
        endcase
    end

endmodule

// File: rtl/exc_sr_mod.sv
// Status rewrite: forces the block, privilege and bank bits to one and passes
// every other bit through. Bit positions are parameters and must be < SR_W.
module exc_sr_mod #(
    parameter int SR_W   = 32,
    parameter int BL_POS = 28,
    parameter int RB_POS = 29,
    parameter int MD_POS = 30
) (
    input  logic [SR_W-1:0] sr_in,
    output logic [SR_W-1:0] sr_new
);

    // One cell per status bit: set or pass.
    for (genvar i = 0; i < SR_W; i++) begin : g_bit
        if (i == BL_POS || i == RB_POS || i == MD_POS) begin : g_force
            assign sr_new[i] = 1'b1;
        end else begin : g_pass
            assign sr_new[i] = sr_in[i];
        end
    end

endmodule

// File: rtl/exc_entry_seq.sv
// Exception entry sequencer top. Samples the request strobes on each rising
// edge and, in that one edge, loads the shadow PC and status, the event code,
// the new status word and the redirect address, pulsing redirect_valid.
// Assumes the pipeline holds each strobe for exactly the cycle it means.
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int PC_W        = 32,
    parameter int SR_W        = 32,
    parameter int SLOT_CAUSES = 4,
    parameter int INSN_BYTES  = 2,
    parameter int VEC_OFS     = 'h100,
    parameter int BL_POS      = 28,
    parameter int RB_POS      = 29,
    parameter int MD_POS      = 30
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SLOT_CAUSES-1:0] slot_cause,
    input  logic                   req_illegal,
    input  logic                   req_break,
    input  logic                   break_post,
    input  logic [PC_W-1:0]        cur_pc,
    input  logic [PC_W-1:0]        branch_pc,
    input  logic [SR_W-1:0]        sr_in,
    input  logic [PC_W-1:0]        vec_base,
    output logic                   redirect_valid,
    output logic [PC_W-1:0]        redirect_pc,
    output logic [SR_W-1:0]        sr_out,
    output logic [PC_W-1:0]        saved_pc,
    output logic [SR_W-1:0]        saved_sr,
    output logic [EC_W-1:0]        event_code,
    output logic                   blocked_err
);

    localparam logic [PC_W-1:0] OFS = PC_W'(VEC_OFS);

    exc_kind_e       kind;
    logic            accept;
    logic            reject;
    logic [PC_W-1:0] ret_pc;
    logic [SR_W-1:0] sr_new;

    exc_prio_arb #(
        .SLOT_CAUSES (SLOT_CAUSES)
    ) u_arb (
        .slot_cause  (slot_cause),
        .req_illegal (req_illegal),
        .req_break   (req_break),
        .blocked     (sr_in[BL_POS]),
        .kind        (kind),
        .accept      (accept),
        .reject      (reject)
    );

    exc_ret_pc #(
        .PC_W       (PC_W),
        .INSN_BYTES (INSN_BYTES)
    ) u_ret (
        .kind       (kind),
        .break_post (break_post),
        .cur_pc     (cur_pc),
        .branch_pc  (branch_pc),
        .ret_pc     (ret_pc)
    );

    exc_sr_mod #(
        .SR_W   (SR_W),
        .BL_POS (BL_POS),
        .RB_POS (RB_POS),
        .MD_POS (MD_POS)
    ) u_sr (
        .sr_in  (sr_in),
        .sr_new (sr_new)
    );

    // Single-cycle strobes for entry and refusal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_valid <= 1'b0;
            blocked_err    <= 1'b0;
        end else begin
            redirect_valid <= accept;
            blocked_err    <= reject;
        end
    end

    // Shadow and redirect registers, loaded only on an accepted entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_pc <= '0;
            sr_out      <= '0;
            saved_pc    <= '0;
            saved_sr    <= '0;
            event_code  <= '0;
        end else if (accept) begin
            redirect_pc <= vec_base + OFS;
            sr_out      <= sr_new;
            saved_pc    <= ret_pc;
            saved_sr    <= sr_in;
            event_code  <= code_of(kind);
        end
    end

endmodule

// File: rtl/exc_entry_sva.sv
// Checker for exc_entry_seq, attached by bind. Observes ports only.
module exc_entry_sva
    import exc_entry_pkg::*;
#(
    parameter int PC_W        = 32,
    parameter int SR_W        = 32,
    parameter int SLOT_CAUSES = 4,
    parameter int INSN_BYTES  = 2,
    parameter int VEC_OFS     = 'h100,
    parameter int BL_POS      = 28,
    parameter int RB_POS      = 29,
    parameter int MD_POS      = 30
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [SLOT_CAUSES-1:0] slot_cause,
    input logic                   req_illegal,
    input logic                   req_break,
    input logic                   break_post,
    input logic [PC_W-1:0]        cur_pc,
    input logic [PC_W-1:0]        branch_pc,
    input logic [SR_W-1:0]        sr_in,
    input logic [PC_W-1:0]        vec_base,
    input logic                   redirect_valid,
    input logic [PC_W-1:0]        redirect_pc,
    input logic [SR_W-1:0]        sr_out,
    input logic [PC_W-1:0]        saved_pc,
    input logic [SR_W-1:0]        saved_sr,
    input logic [EC_W-1:0]        event_code,
    input logic                   blocked_err
);

    logic any_req;
    logic open_gate;
    assign any_req   = (|slot_cause) | req_illegal | req_break;
    assign open_gate = ~sr_in[BL_POS];

    p_entry_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (any_req && open_gate) |=> (redirect_valid && !blocked_err));

    p_refuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (any_req && !open_gate) |=> (blocked_err && !redirect_valid
            && $stable(saved_pc) && $stable(saved_sr) && $stable(event_code)));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !any_req |=> (!redirect_valid && !blocked_err));

    p_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (any_req && open_gate) |=> (redirect_pc == $past(vec_base) + PC_W'(VEC_OFS)));

    p_sr_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (sr_out[BL_POS] && sr_out[RB_POS] && sr_out[MD_POS]));

    p_slot_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|slot_cause) && open_gate) |=>
            (saved_pc == $past(branch_pc) && event_code == CODE_SLOT));

    p_ill_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|slot_cause) && req_illegal && open_gate) |=>
            (event_code == CODE_ILL && saved_pc == $past(cur_pc)));

    p_post_pc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|slot_cause) && !req_illegal && req_break && break_post && open_gate) |=>
            (saved_pc == $past(cur_pc) + PC_W'(INSN_BYTES) && event_code == CODE_BRK));

    p_saved_sr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (any_req && open_gate) |=> (saved_sr == $past(sr_in)));

endmodule

bind exc_entry_seq exc_entry_sva #(
    .PC_W        (PC_W),
    .SR_W        (SR_W),
    .SLOT_CAUSES (SLOT_CAUSES),
    .INSN_BYTES  (INSN_BYTES),
    .VEC_OFS     (VEC_OFS),
    .BL_POS      (BL_POS),
    .RB_POS      (RB_POS),
    .MD_POS      (MD_POS)
) u_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .slot_cause     (slot_cause),
    .req_illegal    (req_illegal),
    .req_break      (req_break),
    .break_post     (break_post),
    .cur_pc         (cur_pc),
    .branch_pc      (branch_pc),
    .sr_in          (sr_in),
    .vec_base       (vec_base),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .sr_out         (sr_out),
    .saved_pc       (saved_pc),
    .saved_sr       (saved_sr),
    .event_code     (event_code),
    .blocked_err    (blocked_err)
);

// File: tb/exc_entry_seq_bench.sv
// Bench: vector table walked by one loop, then directed reset checks.
module exc_entry_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PW = 16;
    localparam int SW = 32;

    typedef struct packed {
        logic [3:0]    slot;
        logic          ill;
        logic          brk;
        logic          post;
        logic [PW-1:0] pc;
        logic [PW-1:0] bpc;
        logic [SW-1:0] sr;
        logic [PW-1:0] vb;
        logic          e_val;
        logic          e_err;
        logic [PW-1:0] e_spc;
        logic [SW-1:0] e_ssr;
        logic [11:0]   e_code;
        logic [PW-1:0] e_rpc;
        logic [SW-1:0] e_sro;
    } vec_t;

    localparam int NV = 13;
    // R2 illegal, R3/R4 slot causes, R5 break, R8 priority, R7/R5 wrap, R9 refusal
    localparam vec_t VECS [NV] = '{
        '{4'h0,1'b1,1'b0,1'b0,16'h1234,16'h0000,32'h000000F0,16'h8000, 1'b1,1'b0,16'h1234,32'h000000F0,12'h180,16'h8100,32'h700000F0},
        '{4'h1,1'b0,1'b0,1'b0,16'h2002,16'h2000,32'h00000001,16'h4000, 1'b1,1'b0,16'h2000,32'h00000001,12'h1A0,16'h4100,32'h70000001},
        '{4'h2,1'b0,1'b0,1'b0,16'h3006,16'h3004,32'h00000002,16'h0000, 1'b1,1'b0,16'h3004,32'h00000002,12'h1A0,16'h0100,32'h70000002},
        '{4'h4,1'b0,1'b0,1'b0,16'h0010,16'h000E,32'h00000003,16'h0200, 1'b1,1'b0,16'h000E,32'h00000003,12'h1A0,16'h0300,32'h70000003},
        '{4'h8,1'b0,1'b0,1'b0,16'h0052,16'h0050,32'h00000004,16'h1000, 1'b1,1'b0,16'h0050,32'h00000004,12'h1A0,16'h1100,32'h70000004},
        '{4'h0,1'b0,1'b1,1'b0,16'h0600,16'h0000,32'h20000000,16'h8000, 1'b1,1'b0,16'h0600,32'h20000000,12'h1E0,16'h8100,32'h70000000},
        '{4'h0,1'b0,1'b1,1'b1,16'h0600,16'h0000,32'h00000005,16'h8000, 1'b1,1'b0,16'h0602,32'h00000005,12'h1E0,16'h8100,32'h70000005},
        '{4'h1,1'b1,1'b1,1'b1,16'h0700,16'h06FE,32'h00000006,16'h2000, 1'b1,1'b0,16'h06FE,32'h00000006,12'h1A0,16'h2100,32'h70000006},
        '{4'h0,1'b1,1'b1,1'b0,16'h0800,16'h0000,32'h00000007,16'h2000, 1'b1,1'b0,16'h0800,32'h00000007,12'h180,16'h2100,32'h70000007},
        '{4'h0,1'b0,1'b1,1'b1,16'hFFFE,16'h0000,32'h00000008,16'hFF80, 1'b1,1'b0,16'h0000,32'h00000008,12'h1E0,16'h0080,32'h70000008},
        '{4'h0,1'b1,1'b0,1'b0,16'h9999,16'h0000,32'h10000008,16'h1111, 1'b0,1'b1,16'h0000,32'h00000008,12'h1E0,16'h0080,32'h70000008},
        '{4'h0,1'b0,1'b0,1'b0,16'h4444,16'h4444,32'h00000000,16'h4444, 1'b0,1'b0,16'h0000,32'h00000008,12'h1E0,16'h0080,32'h70000008},
        '{4'h3,1'b0,1'b1,1'b1,16'h5550,16'h554E,32'h50000000,16'h3333, 1'b0,1'b1,16'h0000,32'h00000008,12'h1E0,16'h0080,32'h70000008}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    slot_cause = '0;
    logic          req_illegal = 1'b0;
    logic          req_break = 1'b0;
    logic          break_post = 1'b0;
    logic [PW-1:0] cur_pc = '0;
    logic [PW-1:0] branch_pc = '0;
    logic [SW-1:0] sr_in = '0;
    logic [PW-1:0] vec_base = '0;
    logic          redirect_valid;
    logic [PW-1:0] redirect_pc;
    logic [SW-1:0] sr_out;
    logic [PW-1:0] saved_pc;
    logic [SW-1:0] saved_sr;
    logic [11:0]   event_code;
    logic          blocked_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_seq #(
        .PC_W (PW),
        .SR_W (SW)
    ) u_exc_entry_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .slot_cause     (slot_cause),
        .req_illegal    (req_illegal),
        .req_break      (req_break),
        .break_post     (break_post),
        .cur_pc         (cur_pc),
        .branch_pc      (branch_pc),
        .sr_in          (sr_in),
        .vec_base       (vec_base),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .sr_out         (sr_out),
        .saved_pc       (saved_pc),
        .saved_sr       (saved_sr),
        .event_code     (event_code),
        .blocked_err    (blocked_err)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        slot_cause  = '0;
        req_illegal = 1'b0;
        req_break   = 1'b0;
        break_post  = 1'b0;
        sr_in       = '0;
    endtask

    task automatic check_all_zero(input string req);
        check(req, "redirect_valid", 32'(redirect_valid), 32'h0);
        check(req, "blocked_err",    32'(blocked_err),    32'h0);
        check(req, "redirect_pc",    32'(redirect_pc),    32'h0);
        check(req, "sr_out",         sr_out,              32'h0);
        check(req, "saved_pc",       32'(saved_pc),       32'h0);
        check(req, "saved_sr",       saved_sr,            32'h0);
        check(req, "event_code",     32'(event_code),     32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, during and just after reset
        repeat (2) @(negedge clk);
        check_all_zero("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all_zero("R1");

        // Table walk: R2..R9 per row, then R10 pulse end on an idle edge
        for (int i = 0; i < NV; i++) begin
            slot_cause  = VECS[i].slot;
            req_illegal = VECS[i].ill;
            req_break   = VECS[i].brk;
            break_post  = VECS[i].post;
            cur_pc      = VECS[i].pc;
            branch_pc   = VECS[i].bpc;
            sr_in       = VECS[i].sr;
            vec_base    = VECS[i].vb;
            @(negedge clk);
            check("R10", "redirect_valid", 32'(redirect_valid), 32'(VECS[i].e_val));
            check("R9",  "blocked_err",    32'(blocked_err),    32'(VECS[i].e_err));
            check("R3/R5", "saved_pc",     32'(saved_pc),       32'(VECS[i].e_spc));
            check("R2",  "saved_sr",       saved_sr,            VECS[i].e_ssr);
            check("R8",  "event_code",     32'(event_code),     32'(VECS[i].e_code));
            check("R7",  "redirect_pc",    32'(redirect_pc),    32'(VECS[i].e_rpc));
            check("R6",  "sr_out",         sr_out,              VECS[i].e_sro);
            idle_inputs();
            @(negedge clk);
            check("R10", "valid after idle", 32'(redirect_valid), 32'h0);
            check("R9",  "err after idle",   32'(blocked_err),    32'h0);
            check("R10", "saved_pc held",    32'(saved_pc),       32'(VECS[i].e_spc));
        end

        // R1: reset after activity clears everything again
        rst_n = 1'b0;
        @(negedge clk);
        check_all_zero("R1");
        rst_n = 1'b1;

        // R4: a request held across reset release is taken on the first free edge
        slot_cause = 4'h4;
        branch_pc  = 16'h0A0A;
        cur_pc     = 16'h0A0C;
        vec_base   = 16'h0000;
        @(negedge clk);
        check("R4", "slot entry after reset", 32'(event_code), 32'h1A0);
        check("R4", "slot saved_pc",          32'(saved_pc),   32'h0A0A);
        idle_inputs();
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule